// File: doc/BRIEF.md
# Pin Interrupt Dispatch Engine

This block sits next to a table of per-pin routing entries and decides when each input pin turns into a delivery request toward the processors. Each pin has a pending bit that follows level-change requests arriving one per cycle on a small request port. The engine gates every pin by its mask. Edge pins are delivered once per rising change. Level pins are delivered once and then held off until an end-of-interrupt (EOI) for their vector arrives. When several pins are ready, the lowest-numbered one wins.

A delivery request carries the vector, destination, destination mode, trigger mode, delivery mode and pin number of the winning pin. It stays on the outputs until the receiver signals ready, and only one request is outstanding at a time. Together with ready, the receiver reports whether at least one target took the interrupt. For every line request the engine reports, one cycle later, whether an edge assertion merged into one that was still pending.

Routing fields are plain inputs from the table beside the block. Changing them takes effect on the next cycle.

Top module: `irq_route_engine`

## Requirements
- R1: After reset no request is presented, no coalesce report is given, and every pin's pending, remote-hold and edge-sent state is clear.
- R2: A line request with level 0 clears the pin's pending bit, so a masked pin that is raised and then lowered is not delivered after unmasking.
- R3: A level-1 request on an edge pin (trigger input 0) whose pending bit is already set gives coal_flag=1 on the cycle after the request, with coal_valid=1, and causes no delivery. All other requests give coal_flag=0.
- R4: A masked pin (mask bit 1) is never chosen. Unmasking a pin whose pending bit is set leads to a delivery.
- R5: A level pin (trigger input 1) is not chosen while its remote-hold bit is set.
- R6: The remote-hold bit of a level pin is set only when that pin's request completes (dlv_valid and dlv_ready) with dlv_accepted=1. A completion with dlv_accepted=0 leaves it clear, and the pin is offered again.
- R7: An EOI with eoi_level=1 clears the remote-hold bit of every level pin whose vector equals eoi_vector. Such a pin that is unmasked and whose line is still high is delivered again.
- R8: An EOI with eoi_level=0, or one whose vector matches no pin, has no effect on any remote-hold bit.
- R9: Switching a pin from edge to level while its pending bit is set and its remote-hold bit is clear leads to a new delivery.
- R10: An edge pin is delivered once per rising change of its line. Its sent bit is set by the completed request and cleared only by a 0-to-1 change of its pending bit.
- R11: Among ready pins the lowest index is chosen. After a completed request the block waits one idle cycle before presenting the next. The outputs hold their value while dlv_ready is low. The payload is the chosen pin's routing fields.
- R12: Configuring a pin as edge clears its remote-hold bit, so a later switch back to level with a rising line is delivered without an EOI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Line level request strobe |
| set_pin | input | PIN_W | Pin addressed by the request |
| set_level | input | 1 | New line level |
| coal_valid | output | 1 | Report for the request of the previous cycle |
| coal_flag | output | 1 | That request merged into a pending edge |
| cfg_mask | input | NUM_PINS | Per-pin mask, 1 = blocked |
| cfg_level | input | NUM_PINS | Per-pin trigger, 1 = level, 0 = edge |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector, pin i at bits i*VEC_W |
| cfg_dest | input | NUM_PINS*DEST_W | Per-pin destination |
| cfg_dest_logical | input | NUM_PINS | Per-pin destination mode |
| cfg_dmode | input | NUM_PINS*DMODE_W | Per-pin delivery mode |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector being acknowledged |
| eoi_level | input | 1 | EOI trigger mode, 1 = level |
| dlv_valid | output | 1 | Delivery request present |
| dlv_pin | output | PIN_W | Pin being delivered |
| dlv_vector | output | VEC_W | Vector |
| dlv_dest | output | DEST_W | Destination |
| dlv_dest_logical | output | 1 | Destination mode |
| dlv_level | output | 1 | Trigger mode of the pin |
| dlv_dmode | output | DMODE_W | Delivery mode |
| dlv_ready | input | 1 | Receiver takes the request this cycle |
| dlv_accepted | input | 1 | At least one target accepted it |

## Verification
The bench builds the engine with eight pins and 8-bit vectors and destinations. With these values it can make every pin's vector distinct and can cover the top pin (7), the bottom pin (0) and the masked, level and edge pins in one run. Eight pins are enough to stack three ready edge pins behind a stalled receiver, which exposes the priority order and the idle cycle between requests. Distinct vectors make it visible when an EOI aimed at a neighbouring vector wrongly releases a pin.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track (
   input  logic clk,
   input  logic rst_n,
   input  logic set_hit,
   input  logic set_level,
   input  logic trig_level,
   input  logic masked,
   input  logic eoi_hit,
   input  logic done_hit,
   input  logic done_acc,
   output logic pending,
   output logic coalesced
);
   logic irr_q, remote_q, sent_q;
   logic rise;

   assign rise = set_hit & set_level & ~irr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q    <= 1'b0;
         remote_q <= 1'b0;
         sent_q   <= 1'b0;
      end else begin
         if (set_hit)
            irr_q <= set_level;
         if (rise)
            sent_q <= 1'b0;
         else if (done_hit && !trig_level)
            sent_q <= 1'b1;
         if (!trig_level)
            remote_q <= 1'b0;
         else if (done_hit && done_acc)
            remote_q <= 1'b1;
         else if (eoi_hit)
            remote_q <= 1'b0;
      end
   end

   assign pending   = irr_q & ~masked & (trig_level ? ~remote_q : ~sent_q);
   assign coalesced = set_hit & set_level & irr_q & ~trig_level;

   // R6
   remote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(remote_q) |-> $past(done_hit && done_acc && trig_level));
   // R7
   remote_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(remote_q) |-> $past(eoi_hit || !trig_level));
   // R2
   irr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irr_q) |-> $past(set_hit && !set_level));
   // R10
   sent_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sent_q) |-> $past(done_hit));
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned PIN_W    = 3
) (
   input  logic [NUM_PINS-1:0] pend,
   output logic                any,
   output logic [PIN_W-1:0]    idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_PINS - 1; i >= 0; i--) begin
         if (pend[i]) begin
            any = 1'b1;
            idx = PIN_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine #(
   parameter int unsigned NUM_PINS = 8,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned DEST_W   = 8,
   parameter int unsigned DMODE_W  = 3,
   localparam int unsigned PIN_W   = irq_route_pkg::idx_width(NUM_PINS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        set_valid,
   input  logic [PIN_W-1:0]            set_pin,
   input  logic                        set_level,
   output logic                        coal_valid,
   output logic                        coal_flag,
   input  logic [NUM_PINS-1:0]         cfg_mask,
   input  logic [NUM_PINS-1:0]         cfg_level,
   input  logic [NUM_PINS*VEC_W-1:0]   cfg_vector,
   input  logic [NUM_PINS*DEST_W-1:0]  cfg_dest,
   input  logic [NUM_PINS-1:0]         cfg_dest_logical,
   input  logic [NUM_PINS*DMODE_W-1:0] cfg_dmode,
   input  logic                        eoi_valid,
   input  logic [VEC_W-1:0]            eoi_vector,
   input  logic                        eoi_level,
   output logic                        dlv_valid,
   output logic [PIN_W-1:0]            dlv_pin,
   output logic [VEC_W-1:0]            dlv_vector,
   output logic [DEST_W-1:0]           dlv_dest,
   output logic                        dlv_dest_logical,
   output logic                        dlv_level,
   output logic [DMODE_W-1:0]          dlv_dmode,
   input  logic                        dlv_ready,
   input  logic                        dlv_accepted
);
   import irq_route_pkg::*;

   if (NUM_PINS < 2) begin : bad_pins
      $error("irq_route_engine: NUM_PINS must be at least 2");
   end
   if (VEC_W < 4) begin : bad_vec
      $error("irq_route_engine: VEC_W must be at least 4");
   end
   if (DMODE_W < 1 || DEST_W < 1) begin : bad_fields
      $error("irq_route_engine: field widths must be positive");
   end

   logic [NUM_PINS-1:0] pend_vec, coal_vec, set_hit, done_hit, eoi_hit;
   logic                pick_any;
   logic [PIN_W-1:0]    pick_idx;
   logic                busy_q;
   logic                handshake;

   assign handshake = busy_q & dlv_ready;

   for (genvar g = 0; g < NUM_PINS; g++) begin : pin_g
      assign set_hit[g]  = set_valid && (set_pin == PIN_W'(g));
      assign done_hit[g] = handshake && (dlv_pin == PIN_W'(g));
      assign eoi_hit[g]  = eoi_valid && eoi_level &&
                           (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);

      irq_pin_track track_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_hit    (set_hit[g]),
         .set_level  (set_level),
         .trig_level (cfg_level[g] == TRIG_LEVEL),
         .masked     (cfg_mask[g]),
         .eoi_hit    (eoi_hit[g]),
         .done_hit   (done_hit[g]),
         .done_acc   (dlv_accepted),
         .pending    (pend_vec[g]),
         .coalesced  (coal_vec[g])
      );
   end

   irq_low_pick #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) pick_i (
      .pend (pend_vec),
      .any  (pick_any),
      .idx  (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q           <= 1'b0;
         dlv_pin          <= '0;
         dlv_vector       <= '0;
         dlv_dest         <= '0;
         dlv_dest_logical <= 1'b0;
         dlv_level        <= 1'b0;
         dlv_dmode        <= '0;
         coal_valid       <= 1'b0;
         coal_flag        <= 1'b0;
      end else begin
         coal_valid <= set_valid;
         coal_flag  <= |coal_vec;
         if (busy_q) begin
            if (dlv_ready)
               busy_q <= 1'b0;
         end else if (pick_any) begin
            busy_q           <= 1'b1;
            dlv_pin          <= pick_idx;
            dlv_vector       <= cfg_vector[pick_idx*VEC_W +: VEC_W];
            dlv_dest         <= cfg_dest[pick_idx*DEST_W +: DEST_W];
            dlv_dest_logical <= cfg_dest_logical[pick_idx];
            dlv_level        <= cfg_level[pick_idx];
            dlv_dmode        <= cfg_dmode[pick_idx*DMODE_W +: DMODE_W];
         end
      end
   end

   assign dlv_valid = busy_q;

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) && $stable(dlv_vector)));
   // R11
   gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && dlv_ready) |=> !dlv_valid);
   // R11
   prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_any |-> (pend_vec[pick_idx] &&
                    ((pend_vec & ((NUM_PINS'(1) << pick_idx) - NUM_PINS'(1))) == '0)));
   // R4
   mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && pick_any) |=> !$past(cfg_mask[pick_idx]));
endmodule

// File: tb/irq_route_engine_tb_top.sv
`timescale 1ns/1ps
module irq_route_engine_tb_top;
   localparam int N = 8, VW = 8, DW = 8, MW = 3, PW = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0;
   logic set_valid = 1'b0, set_level = 1'b0;
   logic [PW-1:0] set_pin = '0;
   logic coal_valid, coal_flag;
   logic [N-1:0] cfg_mask, cfg_level, cfg_dl;
   logic [VW-1:0] vec_a [N];
   logic [DW-1:0] dst_a [N];
   logic [MW-1:0] dm_a [N];
   logic [N*VW-1:0] cfg_vector;
   logic [N*DW-1:0] cfg_dest;
   logic [N*MW-1:0] cfg_dmode;
   logic eoi_valid = 1'b0, eoi_level = 1'b0;
   logic [VW-1:0] eoi_vector = '0;
   logic dlv_valid, dlv_dest_logical, dlv_level;
   logic [PW-1:0] dlv_pin;
   logic [VW-1:0] dlv_vector;
   logic [DW-1:0] dlv_dest;
   logic [MW-1:0] dlv_dmode;
   logic dlv_ready = 1'b1, dlv_accepted = 1'b1;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         cfg_vector[i*VW +: VW] = vec_a[i];
         cfg_dest[i*DW +: DW]   = dst_a[i];
         cfg_dmode[i*MW +: MW]  = dm_a[i];
      end
   end

   irq_route_engine #(.NUM_PINS(N), .VEC_W(VW), .DEST_W(DW), .DMODE_W(MW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .set_valid(set_valid), .set_pin(set_pin), .set_level(set_level),
      .coal_valid(coal_valid), .coal_flag(coal_flag),
      .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
      .cfg_dest(cfg_dest), .cfg_dest_logical(cfg_dl), .cfg_dmode(cfg_dmode),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
      .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
      .dlv_dest(dlv_dest), .dlv_dest_logical(dlv_dest_logical),
      .dlv_level(dlv_level), .dlv_dmode(dlv_dmode),
      .dlv_ready(dlv_ready), .dlv_accepted(dlv_accepted)
   );

   typedef struct {
      int            pin;
      logic [VW-1:0] vec;
      logic [DW-1:0] dst;
      logic          dl;
      logic          lvl;
      logic [MW-1:0] dm;
   } exp_t;

   exp_t exp_q[$];
   int compared = 0, mismatched = 0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic push_exp(input int p);
      exp_t e;
      e.pin = p; e.vec = vec_a[p]; e.dst = dst_a[p];
      e.dl = cfg_dl[p]; e.lvl = cfg_level[p]; e.dm = dm_a[p];
      exp_q.push_back(e);
   endtask

   // monitor: a request is taken at the next edge when valid and ready are both high
   always @(negedge clk) begin
      if (rst_n && dlv_valid && dlv_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected delivery, pin", int'(dlv_pin), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(dlv_pin) == e.pin && dlv_vector == e.vec && dlv_dest == e.dst &&
                  dlv_dest_logical == e.dl && dlv_level == e.lvl && dlv_dmode == e.dm,
                  "R11 delivery payload, pin", int'(dlv_pin), e.pin);
         end
      end
   end

   task automatic pulse(input int p, input bit lvl, input bit exp_coal, input string tag);
      @(posedge clk) #1;
      set_valid = 1'b1; set_pin = PW'(p); set_level = lvl;
      @(posedge clk) #1;
      set_valid = 1'b0;
      @(negedge clk);
      check(coal_valid && (coal_flag == exp_coal), tag, int'(coal_flag), int'(exp_coal));
   endtask

   task automatic eoi(input int p, input int offs, input bit lvl);
      @(posedge clk) #1;
      eoi_valid = 1'b1; eoi_vector = vec_a[p] + VW'(offs); eoi_level = lvl;
      @(posedge clk) #1;
      eoi_valid = 1'b0;
   endtask

   task automatic quiet(input int n, input string tag);
      repeat (n) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0 && !dlv_valid, tag, exp_q.size(), 0);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         vec_a[i] = VW'(8'h30 + 3 * i);
         dst_a[i] = DW'(8'h10 + i);
         dm_a[i]  = MW'(i);
      end
      cfg_mask  = 8'b0001_0000;
      cfg_level = 8'b0110_0000;
      cfg_dl    = 8'b1010_1010;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!dlv_valid && !coal_valid, "R1 idle after reset", int'(dlv_valid), 0);
      quiet(3, "R1 no spontaneous request");

      // R10: edge pin delivered once per rise
      push_exp(3);
      pulse(3, 1'b1, 1'b0, "R3 first rise not merged");
      quiet(8, "R10 single edge delivery");
      // R3: raise again while pending is set
      pulse(3, 1'b1, 1'b1, "R3 repeated assertion merged");
      quiet(6, "R3 no delivery for merged edge");
      pulse(3, 1'b0, 1'b0, "R3 lowering not merged");
      push_exp(3);
      pulse(3, 1'b1, 1'b0, "R10 fresh rise after low");
      quiet(8, "R10 second edge delivered");

      // R2: masked pin raised and lowered leaves nothing behind
      pulse(4, 1'b1, 1'b0, "R2 masked rise");
      pulse(4, 1'b0, 1'b0, "R2 masked lower");
      @(posedge clk) #1 cfg_mask[4] = 1'b0;
      quiet(6, "R2 cleared pending not delivered");
      // R4: masked pending delivered on unmask
      @(posedge clk) #1 cfg_mask[4] = 1'b1;
      pulse(4, 1'b1, 1'b0, "R4 masked rise");
      quiet(6, "R4 mask blocks delivery");
      push_exp(4);
      @(posedge clk) #1 cfg_mask[4] = 1'b0;
      quiet(8, "R4 unmask delivers");

      // R5 / R7 / R8: level pin 5
      push_exp(5);
      pulse(5, 1'b1, 1'b0, "R3 level pin never merged");
      quiet(8, "R5 one level delivery");
      pulse(5, 1'b1, 1'b0, "R3 level reassert not merged");
      quiet(6, "R5 held by remote bit");
      eoi(5, 1, 1'b1);
      quiet(6, "R8 other vector ignored");
      eoi(5, 0, 1'b0);
      quiet(6, "R8 edge-mode EOI ignored");
      push_exp(5);
      eoi(5, 0, 1'b1);
      quiet(8, "R7 EOI redelivers high line");
      pulse(5, 1'b0, 1'b0, "R2 level lower");
      eoi(5, 0, 1'b1);
      quiet(6, "R7 EOI with low line no delivery");

      // R6: rejected level delivery retried, request held while stalled
      @(posedge clk) #1;
      dlv_ready = 1'b0; dlv_accepted = 1'b0;
      push_exp(6);
      pulse(6, 1'b1, 1'b0, "R3 level pin 6 rise");
      repeat (3) @(negedge clk);
      check(dlv_valid && dlv_pin == 3'd6, "R11 request held while stalled", int'(dlv_pin), 6);
      @(posedge clk) #1 dlv_ready = 1'b1;
      @(posedge clk) #1 dlv_ready = 1'b0;
      @(posedge clk) #1;
      check(dlv_valid && dlv_pin == 3'd6, "R6 rejected request offered again", int'(dlv_valid), 1);
      push_exp(6);
      dlv_accepted = 1'b1; dlv_ready = 1'b1;
      quiet(8, "R6 accepted request not repeated");

      // R11: priority among stacked edge pins
      @(posedge clk) #1 dlv_ready = 1'b0;
      push_exp(7);
      pulse(7, 1'b1, 1'b0, "R3 pin 7 rise");
      push_exp(0);
      push_exp(1);
      pulse(1, 1'b1, 1'b0, "R3 pin 1 rise");
      pulse(0, 1'b1, 1'b0, "R3 pin 0 rise");
      @(posedge clk) #1 dlv_ready = 1'b1;
      quiet(12, "R11 lowest pin first");

      // R9: edge to level with pending set
      push_exp(2);
      pulse(2, 1'b1, 1'b0, "R3 pin 2 rise");
      quiet(8, "R10 pin 2 edge delivery");
      @(posedge clk) #1 cfg_level[2] = 1'b1;
      push_exp(2);
      quiet(8, "R9 switch to level redelivers");

      // R12: edge configuration clears remote hold
      push_exp(5);
      pulse(5, 1'b1, 1'b0, "R3 pin 5 rise");
      quiet(8, "R5 pin 5 delivered");
      pulse(5, 1'b0, 1'b0, "R2 pin 5 lower");
      @(posedge clk) #1 cfg_level[5] = 1'b0;
      repeat (2) @(posedge clk);
      #1 cfg_level[5] = 1'b1;
      quiet(4, "R12 no delivery with low line");
      push_exp(5);
      pulse(5, 1'b1, 1'b0, "R3 pin 5 rise again");
      quiet(8, "R12 delivered without EOI");

      finish_run();
   end
endmodule